// File: doc/BRIEF.md
# Shadow Threshold Load Controller

This block keeps a pair of 32-bit thresholds, a lower and an upper limit, for a signal monitor. Each limit has two registers. The active register is what the monitor uses. The shadow register is where software stages the next value. The monitor never sees a partial update, because a transfer moves both staged values into the active pair in a single clock cycle.

Three events can cause a transfer: a rising edge on the sync input, a rising edge on one strobe picked from a 127-line global strobe bus, and a write of one to a software load bit. A single shadow-enable bit gates all three. When staging is disabled, transfers never happen and software writes the active registers directly. The block does not compare the thresholds against anything. It only supplies them.

Top module: `shadow_thresh_loader`

## Requirements
- R1: After reset, both active limits and both shadow limits are 0. The enable, mode and strobe-select settings are also 0.
- R2: While `shadow_en` is 0, no transfer takes place, and a write to an active limit appears on that output at the next clock edge.
- R3: With `shadow_en` = 1 and `load_mode` = 0, a rising edge on `sync_in` copies both shadow limits into the active limits at the clock edge where the high level is first sampled.
- R4: With `shadow_en` = 1 and `load_mode` = 1, a rising edge on strobe line `gstrobe[strobe_sel-1]` (select value k picks bus bit k-1) copies both limits. Edges on strobe lines that are not selected have no effect.
- R5: A `strobe_sel` value of 0 disables strobe loading for every pattern on the strobe bus.
- R6: A write of 1 to the software load bit (`sw_load_wr` with `sw_load_data` = 1) copies both limits at that clock edge when `shadow_en` = 1, in either load mode. A write of 0, or any such write while `shadow_en` = 0, has no effect.
- R7: A transfer always moves the minimum and the maximum in the same cycle. It copies the shadow values held before that edge, so a shadow write in the same cycle only takes effect at a later transfer.
- R8: When a direct write to an active limit lands in the same cycle as a transfer, the transfer value wins.
- R9: A sync or strobe input that stays high for many cycles causes exactly one transfer, at its rising edge.
- R10: In load mode 0, strobe edges are ignored. In load mode 1, sync edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 32 | Write data for any limit register |
| wr_shd_min | input | 1 | Write strobe, shadow minimum |
| wr_shd_max | input | 1 | Write strobe, shadow maximum |
| wr_act_min | input | 1 | Write strobe, active minimum |
| wr_act_max | input | 1 | Write strobe, active maximum |
| shadow_en | input | 1 | Enables shadow-to-active transfers |
| load_mode | input | 1 | 0: transfer on sync edge, 1: transfer on selected strobe edge |
| sw_load_wr | input | 1 | Write strobe for the software load bit |
| sw_load_data | input | 1 | Value written to the software load bit (1 triggers) |
| sync_in | input | 1 | Sync event input |
| gstrobe | input | 127 | Global load strobe bus |
| strobe_sel | input | 7 | Strobe select, 0 = none, k = line k-1 |
| act_min | output | 32 | Active minimum threshold |
| act_max | output | 32 | Active maximum threshold |

## Verification
Every cycle, the assertions check four things. Nothing transfers or changes on its own while staging is disabled. A direct write lands when staging is off. Every transfer leaves the pair equal to the shadow values from the previous cycle, including when it collides with a direct write. A zero select never produces a strobe edge, and an edge detector never fires two cycles in a row. Only the bench's scenarios can show two things. The first is which event sources are honoured in which load mode, including unselected strobe lines and software writes of 0. The second is the single copy from a long-held level, which needs a shadow change partway through the pulse to become visible at the outputs.

// File: rtl/stl_pkg.sv
package stl_pkg;
  localparam int THR_W = 32;
  localparam int SEL_W = 7;
  localparam int NSTRB = (1 << SEL_W) - 1;

  typedef struct packed {
    logic [THR_W-1:0] hi;
    logic [THR_W-1:0] lo;
  } thr_pair_t;

  // rising edge from current level and previous sample
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // transfer request from the three sources, all gated by the enable
  function automatic logic want_load(input logic en, input logic mode,
                                     input logic sw_one, input logic sync_r,
                                     input logic strb_r);
    return en & (sw_one | (~mode & sync_r) | (mode & strb_r));
  endfunction
endpackage

// File: rtl/stl_edge_det.sv
module stl_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  import stl_pkg::*;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign rise = rise_of(din, prev_q);
endmodule

// File: rtl/stl_strobe_pick.sv
module stl_strobe_pick #(
  parameter int SEL_W = 7,
  localparam int NSTRB = (1 << SEL_W) - 1
) (
  input  logic [NSTRB-1:0] bus,
  input  logic [SEL_W-1:0] sel,
  output logic             picked
);
  logic [NSTRB:0] ext;
  // line 0 of the extended vector is the tied-off "none" choice
  assign ext    = {bus, 1'b0};
  assign picked = ext[sel];
endmodule

// File: rtl/stl_thr_bank.sv
module stl_thr_bank
  import stl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] wr_data,
  input  logic             wr_shd_min,
  input  logic             wr_shd_max,
  input  logic             wr_act_min,
  input  logic             wr_act_max,
  input  logic             load_fire,
  output thr_pair_t        act_q,
  output thr_pair_t        shd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
    end else begin
      if (wr_shd_min) shd_q.lo <= wr_data;
      if (wr_shd_max) shd_q.hi <= wr_data;
    end
  end

  // a transfer takes priority over a direct write; both halves move together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (load_fire) begin
      act_q <= shd_q;
    end else begin
      if (wr_act_min) act_q.lo <= wr_data;
      if (wr_act_max) act_q.hi <= wr_data;
    end
  end
endmodule

// File: rtl/shadow_thresh_loader.sv
module shadow_thresh_loader
  import stl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      wr_data,
  input  logic             wr_shd_min,
  input  logic             wr_shd_max,
  input  logic             wr_act_min,
  input  logic             wr_act_max,
  input  logic             shadow_en,
  input  logic             load_mode,
  input  logic             sw_load_wr,
  input  logic             sw_load_data,
  input  logic             sync_in,
  input  logic [126:0]     gstrobe,
  input  logic [6:0]       strobe_sel,
  output logic [31:0]      act_min,
  output logic [31:0]      act_max
);
  logic      strb_lvl;
  logic      sync_rise;
  logic      strb_rise;
  logic      sw_one;
  logic      load_fire;
  thr_pair_t act_q;
  thr_pair_t shd_q;
  logic [THR_W-1:0] shd_min_w;
  logic [THR_W-1:0] shd_max_w;

  stl_strobe_pick #(.SEL_W(SEL_W)) u_pick (
    .bus(gstrobe), .sel(strobe_sel), .picked(strb_lvl)
  );

  stl_edge_det u_sync_edge (.clk(clk), .rst_n(rst_n), .din(sync_in),  .rise(sync_rise));
  stl_edge_det u_strb_edge (.clk(clk), .rst_n(rst_n), .din(strb_lvl), .rise(strb_rise));

  assign sw_one    = sw_load_wr & sw_load_data;
  assign load_fire = want_load(shadow_en, load_mode, sw_one, sync_rise, strb_rise);

  stl_thr_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_shd_min(wr_shd_min), .wr_shd_max(wr_shd_max),
    .wr_act_min(wr_act_min), .wr_act_max(wr_act_max),
    .load_fire(load_fire), .act_q(act_q), .shd_q(shd_q)
  );

  assign act_min   = act_q.lo;
  assign act_max   = act_q.hi;
  assign shd_min_w = shd_q.lo;
  assign shd_max_w = shd_q.hi;
endmodule

// File: rtl/stl_checker.sv
module stl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        shadow_en,
  input logic        wr_act_min,
  input logic        wr_act_max,
  input logic [31:0] wr_data,
  input logic [6:0]  strobe_sel,
  input logic [31:0] act_min,
  input logic [31:0] act_max,
  input logic [31:0] shd_min,
  input logic [31:0] shd_max,
  input logic        load_fire,
  input logic        sync_rise,
  input logic        strb_rise
);
  p_no_fire_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_en |-> !load_fire);

  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_en && !wr_act_min) |=> $stable(act_min));

  p_direct_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_en && wr_act_max) |=> act_max == $past(wr_data));

  p_pair_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (act_min == $past(shd_min) && act_max == $past(shd_max)));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && wr_act_min) |=> act_min == $past(shd_min));

  p_sel_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_sel == 7'd0) |-> !strb_rise);

  p_one_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> !sync_rise);
endmodule

bind shadow_thresh_loader stl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .shadow_en(shadow_en),
  .wr_act_min(wr_act_min), .wr_act_max(wr_act_max), .wr_data(wr_data),
  .strobe_sel(strobe_sel), .act_min(act_min), .act_max(act_max),
  .shd_min(shd_min_w), .shd_max(shd_max_w), .load_fire(load_fire),
  .sync_rise(sync_rise), .strb_rise(strb_rise)
);

// File: tb/shadow_thresh_loader_tb.sv
module shadow_thresh_loader_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  wr_data = '0;
  logic         wr_shd_min = 0, wr_shd_max = 0, wr_act_min = 0, wr_act_max = 0;
  logic         shadow_en = 0, load_mode = 0, sw_load_wr = 0, sw_load_data = 0;
  logic         sync_in = 0;
  logic [126:0] gstrobe = '0;
  logic [6:0]   strobe_sel = '0;
  logic [31:0]  act_min, act_max;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_smin = 0, m_smax = 0, m_amin = 0, m_amax = 0;
  logic        m_sync_prev = 0, m_strb_prev = 0;

  always #10 clk = ~clk;

  shadow_thresh_loader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_shd_min(wr_shd_min), .wr_shd_max(wr_shd_max),
    .wr_act_min(wr_act_min), .wr_act_max(wr_act_max),
    .shadow_en(shadow_en), .load_mode(load_mode),
    .sw_load_wr(sw_load_wr), .sw_load_data(sw_load_data),
    .sync_in(sync_in), .gstrobe(gstrobe), .strobe_sel(strobe_sel),
    .act_min(act_min), .act_max(act_max)
  );

  function automatic logic sel_line(input logic [126:0] b, input logic [6:0] s);
    if (s == 7'd0) return 1'b0;
    return b[s - 7'd1];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // one clock: predict, clock, compare both outputs, drop pulse inputs
  task automatic step(input string tag);
    logic line, s_edge, t_edge, go;
    line   = sel_line(gstrobe, strobe_sel);
    s_edge = sync_in & !m_sync_prev;
    t_edge = line & !m_strb_prev;
    go = shadow_en && ((sw_load_wr && sw_load_data) ||
                       (load_mode == 1'b0 && s_edge) || (load_mode == 1'b1 && t_edge));
    @(posedge clk);
    if (go) begin
      m_amin = m_smin; m_amax = m_smax;
    end else begin
      if (wr_act_min) m_amin = wr_data;
      if (wr_act_max) m_amax = wr_data;
    end
    if (wr_shd_min) m_smin = wr_data;
    if (wr_shd_max) m_smax = wr_data;
    m_sync_prev = sync_in;
    m_strb_prev = line;
    @(negedge clk);
    check({tag, " min"}, act_min, m_amin);
    check({tag, " max"}, act_max, m_amax);
    wr_shd_min = 0; wr_shd_max = 0; wr_act_min = 0; wr_act_max = 0;
    sw_load_wr = 0; sw_load_data = 0;
  endtask

  task automatic wshd(input logic [31:0] lo, input logic [31:0] hi);
    wr_data = lo; wr_shd_min = 1; step("R7 shadow-lo");
    wr_data = hi; wr_shd_max = 1; step("R7 shadow-hi");
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 reset min", act_min, 32'd0);
    check("R1 reset max", act_max, 32'd0);
    rst_n = 1;
    step("R1 idle");

    // staging disabled: direct writes, no transfers
    wshd(32'd5, 32'd9);
    wr_data = 32'd100; wr_act_min = 1; step("R2 direct min");
    check("R2 direct value", act_min, 32'd100);
    wr_data = 32'd200; wr_act_max = 1; step("R2 direct max");
    sync_in = 1; step("R2 sync ignored");
    sync_in = 0; step("R2 idle");
    sw_load_wr = 1; sw_load_data = 1; step("R6 sw while disabled");
    check("R6 disabled no copy", act_min, 32'd100);

    // mode 0: sync edge
    shadow_en = 1;
    sync_in = 1; step("R3 sync edge");
    check("R3 sync copied", act_max, 32'd9);
    wshd(32'd7, 32'd11);
    step("R9 held high");
    check("R9 one copy", act_min, 32'd5);
    strobe_sel = 7'd10; gstrobe[9] = 1; step("R10 strobe in mode0");
    check("R10 strobe ignored", act_min, 32'd5);
    gstrobe = '0; sync_in = 0; step("R3 idle");

    // mode 1: selected strobe
    load_mode = 1;
    sync_in = 1; step("R10 sync in mode1");
    check("R10 sync ignored", act_min, 32'd5);
    sync_in = 0;
    gstrobe[20] = 1; step("R4 other line");
    check("R4 other line ignored", act_min, 32'd5);
    gstrobe[9] = 1; step("R4 selected edge");
    check("R4 selected copied", act_min, 32'd7);
    gstrobe = '0; wshd(32'd1, 32'd2);
    strobe_sel = 7'd0; gstrobe = '1; step("R5 sel zero");
    check("R5 no copy", act_min, 32'd7);
    gstrobe = '0; strobe_sel = 7'd127; step("R4 idle");
    gstrobe[126] = 1; step("R4 top line");
    check("R4 top line copied", act_max, 32'd2);
    gstrobe = '0;

    // software load
    wshd(32'd30, 32'd40);
    sw_load_wr = 1; sw_load_data = 0; step("R6 write zero");
    check("R6 zero no effect", act_min, 32'd1);
    sw_load_wr = 1; sw_load_data = 1; step("R6 sw load");
    check("R6 sw copied", act_min, 32'd30);

    // collision and same-cycle shadow write
    wshd(32'd50, 32'd60);
    sw_load_wr = 1; sw_load_data = 1; wr_act_min = 1; wr_data = 32'hDEAD; step("R8 collision");
    check("R8 transfer wins", act_min, 32'd50);
    sw_load_wr = 1; sw_load_data = 1; wr_shd_min = 1; wr_data = 32'd77; step("R7 same-cycle shadow");
    check("R7 old shadow used", act_min, 32'd50);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      shadow_en  = ($urandom % 4) != 0;
      load_mode  = $urandom % 2;
      if (($urandom % 16) == 0) strobe_sel = (($urandom % 8) == 0) ? 7'd0 : 7'($urandom % 128);
      sync_in    = (($urandom % 5) == 0) ? ~sync_in : sync_in;
      if (($urandom % 3) == 0) gstrobe[$urandom % 127] ^= 1'b1;
      wr_data    = $urandom;
      wr_shd_min = ($urandom % 4) == 0;
      wr_shd_max = ($urandom % 4) == 0;
      wr_act_min = ($urandom % 6) == 0;
      wr_act_max = ($urandom % 6) == 0;
      sw_load_wr = ($urandom % 8) == 0;
      sw_load_data = $urandom % 2;
      step("R7 random");
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule